// File: doc/BRIEF.md
# Buffered SPI Client Transmit Path

This block is the data path of an SPI client (slave). It runs on a system clock and treats the serial clock, the serial input and the active-low select as asynchronous inputs that pass through two-flop synchronizers. Bits are captured on each rising serial-clock edge and the transmit shift register advances on each falling edge, most significant bit first, eight bits per byte. The bit counter restarts whenever select is released.

Software writes transmit bytes through a one-cycle write strobe and reads the last received byte from a read port. When buffering is enabled, every write lands in a one-entry transmit buffer in front of the shift register. A second control bit picks how the first byte goes out. In dummy-first mode the shift register sends whatever it already holds and the buffered byte follows on the next transfer. In wait-for-receive mode a byte written while the client is deselected is moved into the shift register at once.

Three flags report progress. Buffer-empty drops on an accepted write and rises when the buffered byte moves into the shift register. Receive-complete follows one clock later. Transfer-complete follows one clock after that, and only when nothing is left waiting.

Top module: `spi_buf_client`

## Requirements
- R1: After reset flagDre is 1, flagRxc and flagTxc are 0, rdData is 0x00 and miso is 0.
- R2: miso presents shift-register bit 7 before each rising serial-clock edge and the register moves one place toward bit 7 on each falling edge. mosi is captured on rising edges, MSB first. After the eighth rising edge, rdData holds the byte received.
- R3: With bufEn=1 and waitRx=0, the first transfer after a write sends the shift-register contents. These are the last byte received, or 0x00 after reset. The written byte goes out on the following transfer.
- R4: With bufEn=1 and waitRx=1, a byte accepted while ssN is high and the shift register holds no unsent written byte is moved into the shift register within two clocks. flagDre returns to 1 and the next transfer sends that byte.
- R5: An accepted write to the empty buffer makes flagDre 0 on the next clock.
- R6: At the end of a byte, a full buffer is copied into the shift register and flagDre rises on the next clock.
- R7: flagRxc is set two clocks after the final rising edge is detected, which is one clock after flagDre rises when a copy took place.
- R8: flagTxc is set one clock after flagRxc, and only when the buffer was empty at the end of the byte and is still empty.
- R9: A write made while flagDre is 0 is dropped, and the buffer keeps its earlier byte.
- R10: Releasing ssN part-way through a byte discards the partial byte. No flag is set, rdData is unchanged, and the next byte counts from bit 7 again.
- R11: A pulse on clrRxc clears only flagRxc, and a pulse on clrTxc clears only flagTxc.
- R12: With bufEn=0, a write while ssN is high loads the shift register directly and flagDre stays 1. A write while ssN is low is ignored.
- R13: With bufEn=1 and waitRx=0, a write landing near the end of a byte, including its final clock, is never lost. The byte is sent exactly once within the next two transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host, idle low |
| mosi | input | 1 | Serial data from the host |
| ssN | input | 1 | Active-low client select |
| miso | output | 1 | Serial data to the host (shift-register MSB) |
| bufEn | input | 1 | 1 routes writes through the transmit buffer |
| waitRx | input | 1 | 1 selects wait-for-receive loading, 0 dummy-first |
| wrEn | input | 1 | One-cycle data write strobe |
| wrData | input | 8 | Byte written with wrEn |
| rdData | output | 8 | Last completely received byte |
| clrRxc | input | 1 | Clears flagRxc |
| clrTxc | input | 1 | Clears flagTxc |
| flagDre | output | 1 | Transmit buffer empty |
| flagRxc | output | 1 | Receive complete |
| flagTxc | output | 1 | Transfer complete |

## Verification
The critical coincidence is a software write that lands in the same clock as the end-of-byte copy from the buffer into the shift register. The bench moves the write strobe across a window of clock offsets around the final rising edge of a byte, so the write falls before, on and after the internal end-of-byte cycle. For every offset it runs two more transfers and requires the written byte to appear on miso exactly once. This holds whether the byte was copied at once or waited behind a dummy byte.

// File: rtl/spibuf_pkg.sv
package spibuf_pkg;
  localparam int DATA_W = 8;

  // Strobes issued by control to the datapath, valid for one clock
  typedef struct packed {
    logic sampleNow;    // capture mosi (rising edge)
    logic shiftNow;     // advance shift register (falling edge)
    logic xferEnd;      // final rising edge of a byte
    logic loadBuf;      // copy buffer into shift register at byte end
    logic copyBuf;      // copy buffer into shift register while idle
    logic bufWrite;     // accept wrData into the buffer
    logic directWrite;  // unbuffered write straight into shift register
  } spiStrobe_t;
endpackage

// File: rtl/spibuf_sync.sv
module spibuf_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      for (int s = STAGES - 1; s > 0; s--) chain[s] <= chain[s-1];
      chain[0] <= din;
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/spibuf_ctrl.sv
module spibuf_ctrl
  import spibuf_pkg::*;
#(
  parameter int WIDTH = DATA_W
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sckS,
  input  logic       ssS,
  input  logic       bufEn,
  input  logic       waitRx,
  input  logic       wrEn,
  input  logic       clrRxc,
  input  logic       clrTxc,
  output spiStrobe_t strb,
  output logic       flagDre,
  output logic       flagRxc,
  output logic       flagTxc
);
  localparam int CNT_W = $clog2(WIDTH);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WIDTH - 1);

  logic             sckPrev;
  logic [CNT_W-1:0] bitCnt;
  logic             pendShift;
  logic             txFull;
  logic             shValid;
  logic             endD1, endD2, emptyD1, emptyD2;
  logic             selected, rise, fall, lastBit;

  assign selected = !ssS;
  assign rise     = selected && sckS && !sckPrev;
  assign fall     = selected && !sckS && sckPrev;
  assign lastBit  = rise && (bitCnt == LAST_BIT);

  always_comb begin
    strb.sampleNow   = rise;
    strb.shiftNow    = fall && pendShift;
    strb.xferEnd     = lastBit;
    strb.loadBuf     = lastBit && txFull;
    strb.copyBuf     = bufEn && waitRx && ssS && txFull && !shValid;
    strb.bufWrite    = wrEn && bufEn && !txFull;
    strb.directWrite = wrEn && !bufEn && ssS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev   <= 1'b0;
      bitCnt    <= '0;
      pendShift <= 1'b0;
    end else begin
      sckPrev <= sckS;
      if (!selected) begin
        bitCnt    <= '0;
        pendShift <= 1'b0;
      end else if (rise) begin
        bitCnt    <= lastBit ? '0 : bitCnt + CNT_W'(1);
        pendShift <= !lastBit;
      end else if (fall) begin
        pendShift <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txFull  <= 1'b0;
      shValid <= 1'b0;
    end else begin
      if (strb.loadBuf || strb.copyBuf) txFull <= 1'b0;
      else if (strb.bufWrite)           txFull <= 1'b1;
      if (strb.loadBuf || strb.copyBuf || strb.directWrite) shValid <= 1'b1;
      else if (strb.xferEnd)                                shValid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      endD1   <= 1'b0;
      endD2   <= 1'b0;
      emptyD1 <= 1'b0;
      emptyD2 <= 1'b0;
      flagRxc <= 1'b0;
      flagTxc <= 1'b0;
    end else begin
      endD1   <= strb.xferEnd;
      emptyD1 <= strb.xferEnd && !txFull;
      endD2   <= endD1;
      emptyD2 <= emptyD1;
      if (endD1)       flagRxc <= 1'b1;
      else if (clrRxc) flagRxc <= 1'b0;
      if (endD2 && emptyD2 && !txFull) flagTxc <= 1'b1;
      else if (clrTxc)                 flagTxc <= 1'b0;
    end
  end

  assign flagDre = !txFull;
endmodule

// File: rtl/spibuf_dpath.sv
module spibuf_dpath
  import spibuf_pkg::*;
#(
  parameter int WIDTH = DATA_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  spiStrobe_t       strb,
  input  logic             mosiS,
  input  logic [WIDTH-1:0] wrData,
  output logic             shMsb,
  output logic [WIDTH-1:0] rxData
);
  logic [WIDTH-1:0] shReg;
  logic [WIDTH-1:0] txBuf;
  logic             sampleBit;
  logic [WIDTH-1:0] rxByte;

  assign rxByte = {shReg[WIDTH-2:0], mosiS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg     <= '0;
      txBuf     <= '0;
      sampleBit <= 1'b0;
      rxData    <= '0;
    end else begin
      if (strb.sampleNow) sampleBit <= mosiS;
      if (strb.bufWrite)  txBuf <= wrData;
      if (strb.xferEnd)   rxData <= rxByte;
      if (strb.loadBuf || strb.copyBuf) shReg <= txBuf;
      else if (strb.xferEnd)            shReg <= rxByte;
      else if (strb.directWrite)        shReg <= wrData;
      else if (strb.shiftNow)           shReg <= {shReg[WIDTH-2:0], sampleBit};
    end
  end

  assign shMsb = shReg[WIDTH-1];
endmodule

// File: rtl/spi_buf_client.sv
module spi_buf_client
  import spibuf_pkg::*;
#(
  parameter int WIDTH = DATA_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sck,
  input  logic             mosi,
  input  logic             ssN,
  output logic             miso,
  input  logic             bufEn,
  input  logic             waitRx,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  input  logic             clrRxc,
  input  logic             clrTxc,
  output logic             flagDre,
  output logic             flagRxc,
  output logic             flagTxc
);
  logic       sckSync, mosiSync, ssSync;
  spiStrobe_t strb;

  spibuf_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rstN(rstN),
    .din({ssN, mosi, sck}),
    .dout({ssSync, mosiSync, sckSync})
  );

  spibuf_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .sckS(sckSync), .ssS(ssSync),
    .bufEn(bufEn), .waitRx(waitRx), .wrEn(wrEn),
    .clrRxc(clrRxc), .clrTxc(clrTxc), .strb(strb),
    .flagDre(flagDre), .flagRxc(flagRxc), .flagTxc(flagTxc)
  );

  spibuf_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .mosiS(mosiSync),
    .wrData(wrData), .shMsb(miso), .rxData(rdData)
  );
endmodule

// File: rtl/spibuf_checker.sv
module spibuf_checker
  import spibuf_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       bufEn,
  input logic       flagDre,
  input logic       flagRxc,
  input logic       flagTxc,
  input logic       ssSync,
  input spiStrobe_t strb
);
  a_r5_accept_lowers_dre: assert property (@(posedge clk) disable iff (!rstN)
    (flagDre && wrEn && bufEn) |=> !flagDre);

  a_r9_drop_when_full: assert property (@(posedge clk) disable iff (!rstN)
    (!flagDre && wrEn) |-> !strb.bufWrite);

  a_r6_dre_rise_on_copy: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagDre) |-> ($past(strb.loadBuf) || $past(strb.copyBuf)));

  a_r7_rxc_timing: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagRxc) |-> $past(strb.xferEnd, 2));

  a_r8_txc_timing: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagTxc) |-> $past(strb.xferEnd, 3));

  a_r10_idle_no_bits: assert property (@(posedge clk) disable iff (!rstN)
    ssSync |-> (!strb.xferEnd && !strb.sampleNow));
endmodule

bind spi_buf_client spibuf_checker u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .bufEn(bufEn),
  .flagDre(flagDre), .flagRxc(flagRxc), .flagTxc(flagTxc),
  .ssSync(ssSync), .strb(strb)
);

// File: tb/spi_buf_client_tb.sv
module spi_buf_client_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic clk = 1'b0, rstN = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, ssN = 1'b1;
  logic bufEn = 1'b1, waitRx = 1'b0, wrEn = 1'b0, clrRxc = 1'b0, clrTxc = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic miso, flagDre, flagRxc, flagTxc;
  logic [7:0] rdData;

  int nChecks = 0, nErr = 0, cyc = 0;
  int dreRise = -1000, rxcRise = -1000, txcRise = -1000;
  logic preDre = 1'b1, preRxc = 1'b0, preTxc = 1'b0;
  bit finished = 1'b0;
  logic [7:0] mi, m1, m2;

  spi_buf_client u_dut (
    .clk(clk), .rstN(rstN), .sck(sck), .mosi(mosi), .ssN(ssN), .miso(miso),
    .bufEn(bufEn), .waitRx(waitRx), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .clrRxc(clrRxc), .clrTxc(clrTxc),
    .flagDre(flagDre), .flagRxc(flagRxc), .flagTxc(flagTxc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    if (flagDre && !preDre) dreRise = cyc;
    if (flagRxc && !preRxc) rxcRise = cyc;
    if (flagTxc && !preTxc) txcRise = cyc;
    preDre = flagDre; preRxc = flagRxc; preTxc = flagTxc;
  end

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doWrite(input logic [7:0] v);
    @(negedge clk); wrEn = 1'b1; wrData = v;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic clearFlags();
    @(negedge clk); clrRxc = 1'b1; clrTxc = 1'b1;
    @(negedge clk); clrRxc = 1'b0; clrTxc = 1'b0;
    waitClk(2);
  endtask

  // One full byte; wrOff >= 0 pulses a write wrOff clocks after the last rising edge
  task automatic xfer(input logic [7:0] mo, input int wrOff, input logic [7:0] wv,
                      output logic [7:0] got);
    dreRise = -1000; rxcRise = -1000; txcRise = -1000;
    @(negedge clk); ssN = 1'b0;
    waitClk(HALF);
    for (int b = 7; b >= 0; b--) begin
      mosi = mo[b];
      waitClk(HALF);
      got[b] = miso;
      sck = 1'b1;
      if (b == 0 && wrOff >= 0) begin
        waitClk(wrOff);
        wrEn = 1'b1; wrData = wv;
        @(negedge clk); wrEn = 1'b0;
        waitClk(HALF - 1 - wrOff);
      end else begin
        waitClk(HALF);
      end
      sck = 1'b0;
    end
    waitClk(HALF);
    ssN = 1'b1;
    waitClk(HALF + 4);
  endtask

  task automatic partial(input logic [7:0] mo, input int nBits);
    @(negedge clk); ssN = 1'b0;
    waitClk(HALF);
    for (int b = 7; b > 7 - nBits; b--) begin
      mosi = mo[b]; waitClk(HALF);
      sck = 1'b1; waitClk(HALF);
      sck = 1'b0;
    end
    waitClk(HALF);
    ssN = 1'b1;
    waitClk(HALF + 4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nErr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    waitClk(3);
    rstN = 1'b1;
    waitClk(3);
    chk("R1 dre", flagDre, 1); chk("R1 rxc", flagRxc, 0); chk("R1 txc", flagTxc, 0);
    chk("R1 rdData", rdData, 8'h00); chk("R1 miso", miso, 0);

    // Dummy-first buffered mode
    bufEn = 1'b1; waitRx = 1'b0;
    doWrite(8'h43); waitClk(1);
    chk("R5 dre low after write", flagDre, 0);
    xfer(8'hA1, -1, 8'h00, mi);
    chk("R3 dummy byte after reset", mi, 8'h00);
    chk("R2 received byte", rdData, 8'hA1);
    chk("R6 dre high after copy", flagDre, 1);
    chk("R7 rxc set", flagRxc, 1);
    chk("R7 rxc one clock after dre", rxcRise - dreRise, 1);
    chk("R8 txc held while buffer used", flagTxc, 0);
    doWrite(8'h44); doWrite(8'h45);
    chk("R9 buffer still full", flagDre, 0);
    clearFlags();
    xfer(8'hB2, -1, 8'h00, mi);
    chk("R3 buffered byte follows", mi, 8'h43);
    chk("R8 txc clear with copy", flagTxc, 0);
    clearFlags();
    xfer(8'hC3, -1, 8'h00, mi);
    chk("R9 dropped write not sent", mi, 8'h44);
    chk("R8 txc set when drained", flagTxc, 1);
    chk("R8 txc one clock after rxc", txcRise - rxcRise, 1);
    xfer(8'hD4, -1, 8'h00, mi);
    chk("R3 dummy is last received", mi, 8'hC3);
    chk("R2 rdData", rdData, 8'hD4);

    // Wait-for-receive mode
    waitRx = 1'b1;
    clearFlags();
    doWrite(8'h5A); waitClk(2);
    chk("R4 dre back high", flagDre, 1);
    doWrite(8'h66); doWrite(8'h77); waitClk(1);
    chk("R9 dre low while full", flagDre, 0);
    xfer(8'h11, -1, 8'h00, mi);
    chk("R4 direct byte sent first", mi, 8'h5A);
    xfer(8'h22, -1, 8'h00, mi);
    chk("R9 kept byte, not dropped one", mi, 8'h66);
    chk("R8 txc set", flagTxc, 1);

    // Clear inputs
    @(negedge clk); clrRxc = 1'b1; @(negedge clk); clrRxc = 1'b0; waitClk(1);
    chk("R11 rxc cleared", flagRxc, 0); chk("R11 txc kept", flagTxc, 1);
    @(negedge clk); clrTxc = 1'b1; @(negedge clk); clrTxc = 1'b0; waitClk(1);
    chk("R11 txc cleared", flagTxc, 0); chk("R11 rxc kept clear", flagRxc, 0);

    // Abandoned partial byte
    partial(8'hF0, 3);
    chk("R10 no rxc", flagRxc, 0); chk("R10 no txc", flagTxc, 0);
    chk("R10 rdData kept", rdData, 8'h22);
    doWrite(8'h3C); waitClk(2);
    xfer(8'h81, -1, 8'h00, mi);
    chk("R10 count restarts", mi, 8'h3C);
    chk("R10 full byte after restart", rdData, 8'h81);

    // Sweep of byte values in wait-for-receive mode
    for (int i = 0; i < 16; i++) begin
      logic [7:0] v;
      v = 8'((i * 37 + 9) & 255);
      doWrite(v); waitClk(2);
      xfer(~v, -1, 8'h00, mi);
      chk("R4 sweep miso", mi, v);
      chk("R2 sweep rdData", rdData, 8'(~v));
    end

    // Unbuffered mode
    bufEn = 1'b0; waitRx = 1'b0;
    clearFlags();
    doWrite(8'h99); waitClk(1);
    chk("R12 dre stays high", flagDre, 1);
    xfer(8'h12, -1, 8'h00, mi);
    chk("R12 direct load sent", mi, 8'h99);
    chk("R8 txc unbuffered", flagTxc, 1);
    xfer(8'h34, 2, 8'hEE, mi);
    chk("R12 dummy after direct", mi, 8'h12);
    xfer(8'h56, -1, 8'h00, mi);
    chk("R12 selected write ignored", mi, 8'h34);

    // Write colliding with the end of a byte
    bufEn = 1'b1; waitRx = 1'b0;
    for (int off = 0; off < 6; off++) begin
      logic [7:0] v;
      v = 8'(8'hA0 + off);
      xfer(8'h0F, off, v, mi);
      xfer(8'h0F, -1, 8'h00, m1);
      xfer(8'h0F, -1, 8'h00, m2);
      chk("R13 byte sent exactly once", int'(m1 == v) + int'(m2 == v), 1);
      chk("R13 buffer drained", flagDre, 1);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule